// File: doc/BRIEF.md
# TMDS Clock-Lane Pattern Generator

This block makes the 10-bit words that a TMDS transmitter serialises onto its clock lane. Four programmable words are sent in a fixed rotation, one word per character clock. The words decide the clock-lane frequency relative to the character rate. When all four words are 0x01F, each character carries five low bits and five high bits, so the lane runs at one tenth of the bit rate. When the words are 0x000, 0x000, 0x3FF, 0x3FF, the lane runs four times slower. That slower setting is used above a 340 MHz character rate.

The host writes the words into two packed pair registers. Each pair register holds two words, one in each 16-bit half. A load command copies the staged words into a shadow set. A later run command makes the rotation adopt the shadow set, but only when the four-word cycle wraps, so no cycle ever mixes old and new words. A select bit in a test register chooses the normal pattern path or a fixed alternating test word. The serialiser and the analog PHY are outside this block.

Top module: `tmds_clk_pattern_gen`

## Requirements
- R1: During and right after a synchronous active-high reset, `pattern_out` is 0, no pattern set is active, and the normal path is selected.
- R2: Writing register address k (k = 0 for the first pair, 1 for the second) stages bits [9:0] as word 2k and bits [25:16] as word 2k+1. All other data bits are ignored.
- R3: The word index steps 0, 1, 2, 3 and then back to 0, advancing once per clock, and `pattern_out` always shows the active word at the current index.
- R4: Writing the value 1 to the control register (address 2) copies all staged words into the shadow set. This does not change `pattern_out`.
- R5: Writing the value 2 to the control register makes the shadow set active from the next cycle whose index is 0. That first index-0 word is the first word taken from the shadow set.
- R6: Until the first run command takes effect, `pattern_out` is 0 while the normal path is selected.
- R7: Staged words written after a load reach neither the shadow set nor the output until another load is issued.
- R8: Bit 12 of the test register (address 3) set to 1 selects the normal path. Set to 0, `pattern_out` carries 0x155 at even indexes and 0x2AA at odd indexes. The write takes effect on the next output word.
- R9: Any control-register value other than 1 or 2 has no effect.
- R10: The low-rate set (0x01F four times) produces 0x01F on every word. The high-rate set produces 0x000, 0x000, 0x3FF, 0x3FF in order, starting at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0,1 word pairs, 2 control, 3 test |
| wr_data | input | 32 | Register write data |
| pattern_out | output | 10 | Registered clock-lane word for the serialiser |

## Verification
The hardest case to reach from the ports is a run command that arrives at an arbitrary position in the four-word cycle. The same applies when the run command overlaps a reload, or when staged words change between the load and the run. Whether the swap waits for the wrap boundary and uses the shadow set rather than the staged words can only be seen from the order of the output words. The stimulus therefore interleaves pair writes, load, run and unrecognised control values at random spacing, which shifts the command phase relative to the index. A reference model in the bench tracks the index, the staged, shadow and active sets, and the pending swap, and the output is compared with it on every cycle. Directed runs first set up the low-rate and high-rate sets and a stale-staging case.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int unsigned CMD_LOAD = 1;
  localparam int unsigned CMD_RUN  = 2;
endpackage

// File: rtl/tcp_regs.sv
module tcp_regs
  import tcp_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int NUM_WORDS = 4,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 2,
  parameter int TEST_BIT  = 12
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [BUS_W-1:0]                   wr_data,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   shadow_q,
  output logic                               run_cmd,
  output logic                               normal_q,
  output logic                               normal_n
);
  localparam int NPAIR     = NUM_WORDS / 2;
  localparam int HALF_W    = BUS_W / 2;
  localparam int CTRL_ADDR = NPAIR;
  localparam int TEST_ADDR = NPAIR + 1;

  logic [NUM_WORDS-1:0][WORD_W-1:0] stage_q;
  logic is_ctrl, is_test, load_cmd;

  assign is_ctrl  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign is_test  = wr_en && (wr_addr == ADDR_W'(TEST_ADDR));
  assign load_cmd = is_ctrl && (wr_data == BUS_W'(CMD_LOAD));
  assign run_cmd  = is_ctrl && (wr_data == BUS_W'(CMD_RUN));
  assign normal_n = is_test ? wr_data[TEST_BIT] : normal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NPAIR; k++) begin
        if (wr_addr == ADDR_W'(k)) begin
          stage_q[2*k]   <= wr_data[WORD_W-1:0];
          stage_q[2*k+1] <= wr_data[HALF_W+WORD_W-1:HALF_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           shadow_q <= '0;
    else if (load_cmd) shadow_q <= stage_q;
  end

  always_ff @(posedge clk) begin
    if (rst) normal_q <= 1'b1;
    else     normal_q <= normal_n;
  end

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    load_cmd |=> shadow_q == $past(stage_q)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_cmd |=> $stable(shadow_q)); // R7
endmodule

// File: rtl/tcp_seq.sv
module tcp_seq #(
  parameter int WORD_W    = 10,
  parameter int NUM_WORDS = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]   shadow_q,
  input  logic                               run_cmd,
  output logic [$clog2(NUM_WORDS)-1:0]       ph_n,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   act_n,
  output logic                               run_n,
  output logic                               run_q
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  logic [IDX_W-1:0]                 ph_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] act_q;
  logic                             pend_q, pend_n, apply;

  assign apply  = pend_q && (ph_q == LAST);
  assign ph_n   = (ph_q == LAST) ? '0 : ph_q + 1'b1;
  assign act_n  = apply ? shadow_q : act_q;
  assign run_n  = run_q | apply;
  assign pend_n = run_cmd ? 1'b1 : (apply ? 1'b0 : pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      act_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      act_q  <= act_n;
      run_q  <= run_n;
      pend_q <= pend_n;
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(ph_q) == LAST) |-> ph_q == '0); // R3
  AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> ph_q == '0); // R5
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q); // R6
endmodule

// File: rtl/tcp_outmux.sv
module tcp_outmux #(
  parameter int WORD_W    = 10,
  parameter int NUM_WORDS = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [$clog2(NUM_WORDS)-1:0]       ph_n,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]   act_n,
  input  logic                               run_n,
  input  logic                               normal_n,
  input  logic                               run_q,
  input  logic                               normal_q,
  output logic [WORD_W-1:0]                  out_q
);
  function automatic logic [WORD_W-1:0] alt_word(input logic odd);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W; i++) w[i] = ((i % 2) == 1) == odd;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)            out_q <= '0;
    else if (!normal_n) out_q <= alt_word(ph_n[0]);
    else if (!run_n)    out_q <= '0;
    else                out_q <= act_n[ph_n];
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (normal_q && !run_q) |-> out_q == '0); // R6
  AST_TEST_WORD: assert property (@(posedge clk) disable iff (rst)
    !normal_q |-> (out_q == alt_word(1'b0) || out_q == alt_word(1'b1))); // R8
endmodule

// File: rtl/tmds_clk_pattern_gen.sv
module tmds_clk_pattern_gen #(
  parameter int WORD_W    = 10,
  parameter int NUM_WORDS = 4,
  parameter int BUS_W     = 32,
  parameter int TEST_BIT  = 12,
  parameter int ADDR_W    = $clog2(NUM_WORDS / 2 + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [WORD_W-1:0] pattern_out
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic [NUM_WORDS-1:0][WORD_W-1:0] shadow_q, act_n;
  logic [IDX_W-1:0]                 ph_n;
  logic run_cmd, normal_q, normal_n, run_n, run_q;

  tcp_regs #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .BUS_W(BUS_W),
             .ADDR_W(ADDR_W), .TEST_BIT(TEST_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .shadow_q(shadow_q), .run_cmd(run_cmd), .normal_q(normal_q), .normal_n(normal_n)
  );

  tcp_seq #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_seq (
    .clk(clk), .rst(rst), .shadow_q(shadow_q), .run_cmd(run_cmd),
    .ph_n(ph_n), .act_n(act_n), .run_n(run_n), .run_q(run_q)
  );

  tcp_outmux #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_out (
    .clk(clk), .rst(rst), .ph_n(ph_n), .act_n(act_n), .run_n(run_n),
    .normal_n(normal_n), .run_q(run_q), .normal_q(normal_q), .out_q(pattern_out)
  );
endmodule

// File: tb/test_tmds_clk_pattern_gen.sv
`timescale 1ns/1ps
module test_tmds_clk_pattern_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [9:0]  pattern_out;

  int    n_chk = 0, n_err = 0;
  bit    chk_on = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tmds_clk_pattern_gen i_tmds_clk_pattern_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pattern_out(pattern_out)
  );

  // Reference model built from the requirements
  logic [9:0] m_stage [4];
  logic [9:0] m_shadow[4];
  logic [9:0] m_act   [4];
  logic [1:0] m_ph;
  bit         m_run, m_pend, m_norm;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_shadow[i] = 0; m_act[i] = 0; end
      m_ph = 0; m_run = 0; m_pend = 0; m_norm = 1;
    end else begin
      bit apply;
      apply = m_pend && (m_ph == 2'd3);
      if (apply) begin
        for (int i = 0; i < 4; i++) m_act[i] = m_shadow[i];
        m_run = 1; m_pend = 0;
      end
      m_ph = m_ph + 2'd1;
      if (wr_en) begin
        case (wr_addr)
          2'd0, 2'd1: begin
            if (wr_en && wr_addr == 2'd2 && wr_data == 1) ;
          end
          default: ;
        endcase
        if (wr_addr == 2'd2 && wr_data == 32'd1)
          for (int i = 0; i < 4; i++) m_shadow[i] = m_stage[i];
        if (wr_addr == 2'd2 && wr_data == 32'd2) m_pend = 1;
        if (wr_addr <= 2'd1) begin
          m_stage[2*wr_addr]   = wr_data[9:0];
          m_stage[2*wr_addr+1] = wr_data[25:16];
        end
        if (wr_addr == 2'd3) m_norm = wr_data[12];
      end
    end
  end

  function automatic logic [9:0] exp_out();
    if (!m_norm) return m_ph[0] ? 10'h2AA : 10'h155;
    if (!m_run)  return 10'h000;
    return m_act[m_ph];
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: pattern_out=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on && !rst && !done) check(cur_req, pattern_out, exp_out());

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int seen_hi;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", pattern_out, 10'h000);
    chk_on = 1'b1;

    cur_req = "R6"; idle(8);
    // low-rate set with junk in ignored bits
    cur_req = "R2"; wr(2'd0, 32'hFC1F_FC1F); wr(2'd1, 32'h841F_401F);
    cur_req = "R4"; wr(2'd2, 32'd1); idle(6);
    cur_req = "R5"; wr(2'd2, 32'd2); idle(10);
    @(negedge clk); check("R10", pattern_out, 10'h01F);

    // high-rate set
    cur_req = "R10";
    wr(2'd0, 32'h0000_0000); wr(2'd1, 32'h03FF_03FF); wr(2'd2, 32'd1); wr(2'd2, 32'd2);
    idle(8);
    seen_hi = 0;
    repeat (4) begin @(negedge clk); if (pattern_out == 10'h3FF) seen_hi++; end
    check("R10", 10'(seen_hi), 10'd2);

    // stale staging: no load before run
    cur_req = "R7"; wr(2'd0, 32'h0155_02AA); wr(2'd2, 32'd2); idle(12);
    // unknown commands
    cur_req = "R9"; wr(2'd2, 32'd3); wr(2'd2, 32'd0); wr(2'd2, 32'h102); idle(8);
    // test path
    cur_req = "R8"; wr(2'd3, 32'h0000_0000); idle(9);
    wr(2'd3, 32'h0000_1000); idle(6);

    // random mix
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: wr(2'(op), $urandom);
        2:    wr(2'd2, 32'd1);
        3:    wr(2'd2, 32'd2);
        4:    wr(2'd2, $urandom_range(0, 5));
        5:    wr(2'd3, ($urandom_range(0, 7) != 0) ? 32'h1000 : 32'h0);
        default: idle($urandom_range(1, 4));
      endcase
    end
    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule